// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block drives the configuration port of a serial PHY. The port has four separate control strobes: capture-address, capture-data, write and read. It also has a 16-bit data-in bus toward the PHY, a 16-bit data-out bus back from it, and a single acknowledge line. Each strobe runs a four-phase exchange with the PHY. The block raises the strobe and waits until the acknowledge is seen high. It then drops the strobe and waits until the acknowledge is seen low.

A local controller issues commands through a plain request/done interface. There are three commands: set the PHY register address, write a value, and read a value. The block accepts a command only while idle. When the command ends, it pulses done for one cycle, together with an error flag and, for reads, the returned data.

Acknowledge polling is bounded. The acknowledge passes through a two-flop synchronizer and is sampled once per poll interval. The interval length comes from a programmable cycle count. If the expected level has not appeared after ten samples, the command aborts with an error.

A write whose value sets bit 0 resets the PHY. The PHY cannot answer while it resets, so for that write the block raises the write strobe and finishes without waiting for any acknowledge.

Top module: `phy_cr_master`

## Requirements
- R1: After reset all four strobes, done_o, err_o and cr_din_o are 0, and ready_o is 1.
- R2: An address command (op_i = 0) loads wdata_i onto cr_din_o and raises cr_cap_addr_o. The strobe drops once a high acknowledge is sampled. When a low acknowledge is later sampled, done_o pulses with err_o = 0. At most one strobe is high at any time.
- R3: A write command (op_i = 1) with wdata_i bit 0 clear loads cr_din_o and runs a full handshake on cr_cap_data_o, then a full handshake on cr_write_o, then completes with err_o = 0.
- R4: A write command with wdata_i bit 0 set runs the cr_cap_data_o handshake, then raises cr_write_o. In that same cycle it pulses done_o with err_o = 0 and waits for no acknowledge. cr_write_o stays high until the next command is accepted.
- R5: A read command (op_i = 2) raises cr_read_o. At the sample where acknowledge is seen high, it captures cr_dout_i into rdata_o and drops cr_read_o. After the low acknowledge it completes. rdata_o holds its value until the next read.
- R6: Polling: cr_ack_i passes through two flops. A wait phase takes its first sample poll_gap_i+1 cycles after it begins, and then samples every poll_gap_i+1 cycles. The attempt count restarts at each new phase.
- R7: If ten successive samples in one wait phase miss the expected level, done_o pulses with err_o = 1 and all strobes are low.
- R8: done_o lasts exactly one cycle. A request made while ready_o is 0 is ignored and changes neither cr_din_o nor the command sequence. A request with op_i = 3 is ignored: ready_o stays 1 and no strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| poll_gap_i | input | GAP_W | Cycles between acknowledge samples, minus one |
| req_i | input | 1 | Command request, taken while ready_o is 1 |
| op_i | input | 2 | Command: 0 address, 1 write, 2 read, 3 ignored |
| wdata_i | input | DATA_W | Address or write value |
| ready_o | output | 1 | Idle, can accept a command |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout status of the last command, valid with done_o |
| rdata_o | output | DATA_W | Last read value |
| cr_din_o | output | DATA_W | Data-in bus to the PHY |
| cr_cap_addr_o | output | 1 | Capture-address strobe |
| cr_cap_data_o | output | 1 | Capture-data strobe |
| cr_write_o | output | 1 | Write strobe |
| cr_read_o | output | 1 | Read strobe |
| cr_ack_i | input | 1 | Acknowledge from the PHY |
| cr_dout_i | input | DATA_W | Data-out bus from the PHY |

## Verification
A wrong phase or a wrong attempt count shows at the ports as a strobe that drops one interval early or late, or as done_o pulsing at the wrong cycle. The bench compares every strobe and done_o against its reference model on every clock, so such a fault is flagged within one poll interval of where it occurs. A lost reset-write flag shows up as a write that either hangs waiting for an acknowledge or returns done_o two phases too soon. A captured read value taken at the wrong sample shows up in rdata_o at the completion of that command.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } cr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_HI = 2'd1,
    ST_WAIT_LO = 2'd2
  } cr_state_e;

  localparam int unsigned NUM_STB   = 4;
  localparam logic [1:0]  SEL_CAPA  = 2'd0;
  localparam logic [1:0]  SEL_CAPD  = 2'd1;
  localparam logic [1:0]  SEL_WR    = 2'd2;
  localparam logic [1:0]  SEL_RD    = 2'd3;
  localparam int unsigned RESET_BIT = 0;
endpackage

// File: rtl/phy_cr_sync.sv
module phy_cr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/phy_cr_poll_timer.sv
module phy_cr_poll_timer #(
  parameter int unsigned GAP_W     = 16,
  parameter int unsigned MAX_POLLS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             sample_o,
  output logic             last_o
);
  localparam int unsigned TRY_W = $clog2(MAX_POLLS + 1);

  logic             active_q;
  logic [GAP_W-1:0] gap_q;
  logic [TRY_W-1:0] tries_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      gap_q    <= '0;
      tries_q  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      gap_q    <= gap_i;
      tries_q  <= '0;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (gap_q == '0) begin
        gap_q   <= gap_i;
        tries_q <= tries_q + 1'b1;
      end else begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end

  assign sample_o = active_q && (gap_q == '0);
  assign last_o   = (tries_q == TRY_W'(MAX_POLLS - 1));

  // failing final sample always stops the timer before another increment
  assert_tries_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q < TRY_W'(MAX_POLLS));
  assert_sample_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && !start_i && !stop_i) |=> (gap_q == $past(gap_i)));
endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
  import phy_cr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [1:0]           op_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 ack_s_i,
  input  logic [DATA_W-1:0]    dout_i,
  input  logic                 sample_i,
  input  logic                 last_i,
  output logic                 tmr_start_o,
  output logic                 tmr_stop_o,
  output logic                 ready_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [DATA_W-1:0]    din_o,
  output logic [NUM_STB-1:0]   stb_o
);
  cr_state_e            state_q, state_n;
  logic [1:0]           sel_q, sel_n;
  logic [NUM_STB-1:0]   stb_q, stb_n;
  logic [DATA_W-1:0]    din_q, din_n, rdata_q, rdata_n;
  logic                 rstw_q, rstw_n, done_q, done_n, err_q, err_n;

  function automatic logic [NUM_STB-1:0] onehot(input logic [1:0] s);
    return NUM_STB'(1) << s;
  endfunction

  always_comb begin
    state_n     = state_q;
    sel_n       = sel_q;
    stb_n       = stb_q;
    din_n       = din_q;
    rdata_n     = rdata_q;
    rstw_n      = rstw_q;
    err_n       = err_q;
    done_n      = 1'b0;
    tmr_start_o = 1'b0;
    tmr_stop_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && cr_op_e'(op_i) != OP_NONE) begin
          tmr_start_o = 1'b1;
          state_n     = ST_WAIT_HI;
          rstw_n      = 1'b0;
          unique case (cr_op_e'(op_i))
            OP_ADDR:  begin din_n = wdata_i; sel_n = SEL_CAPA; end
            OP_WRITE: begin din_n = wdata_i; sel_n = SEL_CAPD; rstw_n = wdata_i[RESET_BIT]; end
            default:  sel_n = SEL_RD;
          endcase
          stb_n = onehot(sel_n);
        end
      end
      ST_WAIT_HI: begin
        if (sample_i) begin
          if (ack_s_i) begin
            stb_n       = '0;
            tmr_start_o = 1'b1;
            state_n     = ST_WAIT_LO;
            if (sel_q == SEL_RD) rdata_n = dout_i;
          end else if (last_i) begin
            stb_n      = '0;
            tmr_stop_o = 1'b1;
            state_n    = ST_IDLE;
            done_n     = 1'b1;
            err_n      = 1'b1;
          end
        end
      end
      ST_WAIT_LO: begin
        if (sample_i) begin
          if (!ack_s_i) begin
            if (sel_q == SEL_CAPD) begin
              sel_n = SEL_WR;
              stb_n = onehot(SEL_WR);
              if (rstw_q) begin
                // PHY in reset cannot acknowledge: finish with strobe raised
                tmr_stop_o = 1'b1;
                state_n    = ST_IDLE;
                done_n     = 1'b1;
                err_n      = 1'b0;
              end else begin
                tmr_start_o = 1'b1;
                state_n     = ST_WAIT_HI;
              end
            end else begin
              tmr_stop_o = 1'b1;
              state_n    = ST_IDLE;
              done_n     = 1'b1;
              err_n      = 1'b0;
            end
          end else if (last_i) begin
            tmr_stop_o = 1'b1;
            state_n    = ST_IDLE;
            done_n     = 1'b1;
            err_n      = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= SEL_CAPA;
      stb_q   <= '0;
      din_q   <= '0;
      rdata_q <= '0;
      rstw_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      sel_q   <= sel_n;
      stb_q   <= stb_n;
      din_q   <= din_n;
      rdata_q <= rdata_n;
      rstw_q  <= rstw_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
  assign din_o   = din_q;
  assign stb_o   = stb_q;

  assert_stb_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_q));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(din_q));
  assert_err_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && err_q) |-> (stb_q == '0));
  assert_wr_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_HI && stb_q[SEL_WR]) |-> !din_q[RESET_BIT]);
  assert_rst_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !err_q && stb_q[SEL_WR]) |-> din_q[RESET_BIT]);
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned GAP_W       = 16,
  parameter int unsigned MAX_POLLS   = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GAP_W-1:0]  poll_gap_i,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cr_din_o,
  output logic              cr_cap_addr_o,
  output logic              cr_cap_data_o,
  output logic              cr_write_o,
  output logic              cr_read_o,
  input  logic              cr_ack_i,
  input  logic [DATA_W-1:0] cr_dout_i
);
  logic               ack_s, sample, last, tmr_start, tmr_stop;
  logic [NUM_STB-1:0] stb;

  phy_cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cr_ack_i),
    .q_o   (ack_s)
  );

  phy_cr_poll_timer #(.GAP_W(GAP_W), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .stop_i  (tmr_stop),
    .gap_i   (poll_gap_i),
    .sample_o(sample),
    .last_o  (last)
  );

  phy_cr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .op_i       (op_i),
    .wdata_i    (wdata_i),
    .ack_s_i    (ack_s),
    .dout_i     (cr_dout_i),
    .sample_i   (sample),
    .last_i     (last),
    .tmr_start_o(tmr_start),
    .tmr_stop_o (tmr_stop),
    .ready_o    (ready_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .rdata_o    (rdata_o),
    .din_o      (cr_din_o),
    .stb_o      (stb)
  );

  assign cr_cap_addr_o = stb[SEL_CAPA];
  assign cr_cap_data_o = stb[SEL_CAPD];
  assign cr_write_o    = stb[SEL_WR];
  assign cr_read_o     = stb[SEL_RD];
endmodule

// File: tb/phy_cr_master_bench.sv
module phy_cr_master_bench;
  localparam int MAXP = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic [15:0] poll_gap_i = 0;
  logic        req_i = 0;
  logic [1:0]  op_i = 0;
  logic [15:0] wdata_i = 0;
  logic        ready_o, done_o, err_o;
  logic [15:0] rdata_o, cr_din_o;
  logic        cr_cap_addr_o, cr_cap_data_o, cr_write_o, cr_read_o;
  logic        cr_ack_i = 0;
  logic [15:0] cr_dout_i = 0;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  phy_cr_master u_phy_cr_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .poll_gap_i(poll_gap_i), .req_i(req_i),
    .op_i(op_i), .wdata_i(wdata_i), .ready_o(ready_o), .done_o(done_o),
    .err_o(err_o), .rdata_o(rdata_o), .cr_din_o(cr_din_o),
    .cr_cap_addr_o(cr_cap_addr_o), .cr_cap_data_o(cr_cap_data_o),
    .cr_write_o(cr_write_o), .cr_read_o(cr_read_o), .cr_ack_i(cr_ack_i),
    .cr_dout_i(cr_dout_i)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, behavioural
  int          m_st, m_sel, m_gc, m_tries;
  logic [15:0] m_din, m_rdata;
  logic [3:0]  m_stb;
  bit          m_done, m_err, m_rstw, m_s1, m_s2;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_sel = 0; m_gc = 0; m_tries = 0; m_din = 0; m_rdata = 0;
      m_stb = 0; m_done = 0; m_err = 0; m_rstw = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      bit seen, hit;
      seen = m_s2; m_s2 = m_s1; m_s1 = cr_ack_i;
      m_done = 0;
      if (m_st == 0) begin
        if (req_i && op_i != 2'd3) begin
          m_gc = poll_gap_i; m_tries = 0; m_st = 1; m_rstw = 0;
          if (op_i == 2'd0) begin m_din = wdata_i; m_sel = 0; end
          else if (op_i == 2'd1) begin m_din = wdata_i; m_sel = 1; m_rstw = wdata_i[0]; end
          else m_sel = 3;
          m_stb = 4'(1 << m_sel);
        end
      end else if (m_gc == 0) begin
        hit = (m_st == 1) ? seen : !seen;
        if (hit) begin
          if (m_st == 1) begin
            m_stb = 0; if (m_sel == 3) m_rdata = cr_dout_i;
            m_st = 2; m_gc = poll_gap_i; m_tries = 0;
          end else if (m_sel == 1) begin
            m_sel = 2; m_stb = 4'b0100;
            if (m_rstw) begin m_st = 0; m_done = 1; m_err = 0; end
            else begin m_st = 1; m_gc = poll_gap_i; m_tries = 0; end
          end else begin
            m_st = 0; m_done = 1; m_err = 0;
          end
        end else if (m_tries == MAXP - 1) begin
          m_stb = 0; m_st = 0; m_done = 1; m_err = 1;
        end else begin
          m_tries++; m_gc = poll_gap_i;
        end
      end else m_gc--;
    end
  end

  // PHY responder and per-cycle comparison
  int        resp_mode = 0, resp_lag = 1;
  logic [7:0] hist = 0;
  logic [15:0] paddr = 0;
  bit saw_capa, saw_capd, saw_wr, saw_rd;

  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      chk({cr_read_o, cr_write_o, cr_cap_data_o, cr_cap_addr_o} == m_stb, "R2 strobes vs model",
          {cr_read_o, cr_write_o, cr_cap_data_o, cr_cap_addr_o}, m_stb);
      chk(done_o == m_done, "R6 done timing vs model", done_o, m_done);
      chk(cr_din_o == m_din, "R3 data-in vs model", cr_din_o, m_din);
      chk(ready_o == (m_st == 0), "R8 ready vs model", ready_o, m_st == 0);
      if (m_done) chk(err_o == m_err, "R7 error vs model", err_o, m_err);
      chk(rdata_o == m_rdata, "R5 read data vs model", rdata_o, m_rdata);
    end
    saw_capa |= cr_cap_addr_o; saw_capd |= cr_cap_data_o;
    saw_wr |= cr_write_o; saw_rd |= cr_read_o;
    hist = {hist[6:0], cr_cap_addr_o | cr_cap_data_o | cr_write_o | cr_read_o};
    if (cr_cap_addr_o) paddr = cr_din_o;
    cr_ack_i  <= (resp_mode == 0) ? hist[resp_lag] : (resp_mode == 2);
    cr_dout_i <= paddr ^ 16'hC3A5;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] d);
    int n;
    while (!ready_o) @(negedge clk_i);
    saw_capa = 0; saw_capd = 0; saw_wr = 0; saw_rd = 0;
    req_i = 1; op_i = op; wdata_i = d;
    @(negedge clk_i);
    req_i = 0;
    n = 0;
    while (!done_o && n < 3000) begin @(negedge clk_i); n++; end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ready_o && !done_o && !err_o && cr_din_o == 0, "R1 reset state", {ready_o, done_o, err_o}, 3'b100);
    chk({cr_read_o, cr_write_o, cr_cap_data_o, cr_cap_addr_o} == 0, "R1 strobes low",
        {cr_read_o, cr_write_o, cr_cap_data_o, cr_cap_addr_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    poll_gap_i = 3; resp_mode = 0; resp_lag = 1;
    run_cmd(2'd0, 16'h0042);
    chk(!err_o && saw_capa && !saw_capd && !saw_wr && !saw_rd, "R2 address op", {err_o, saw_capa}, 2'b01);
    chk(cr_din_o == 16'h0042, "R2 address on data-in", cr_din_o, 16'h0042);

    run_cmd(2'd2, 16'h0000);
    chk(!err_o && saw_rd, "R5 read completes", err_o, 0);
    chk(rdata_o == (16'h0042 ^ 16'hC3A5), "R5 read value", rdata_o, 16'h0042 ^ 16'hC3A5);

    poll_gap_i = 2;
    run_cmd(2'd1, 16'h1234);
    chk(!err_o && saw_capd && saw_wr && !cr_write_o, "R3 write op", {err_o, saw_capd, saw_wr, cr_write_o}, 4'b0110);
    chk(rdata_o == (16'h0042 ^ 16'hC3A5), "R5 read data held", rdata_o, 16'h0042 ^ 16'hC3A5);

    run_cmd(2'd1, 16'h0001);
    chk(!err_o && saw_capd && cr_write_o, "R4 reset write done with strobe up", {err_o, cr_write_o}, 2'b01);
    @(negedge clk_i);
    chk(cr_write_o && !done_o, "R4 write strobe held, R8 done pulse", {cr_write_o, done_o}, 2'b10);
    repeat (4) @(negedge clk_i);
    chk(cr_write_o, "R4 write strobe still held", cr_write_o, 1);
    run_cmd(2'd0, 16'h0010);
    chk(!err_o && !cr_write_o, "R4 next command clears write", {err_o, cr_write_o}, 2'b00);

    poll_gap_i = 0; resp_lag = 2;
    run_cmd(2'd0, 16'h0077);
    chk(!err_o, "R6 fast polling succeeds", err_o, 0);
    poll_gap_i = 20; resp_lag = 6;
    run_cmd(2'd2, 16'h0000);
    chk(!err_o && rdata_o == (16'h0077 ^ 16'hC3A5), "R6 slow polling read", rdata_o, 16'h0077 ^ 16'hC3A5);

    poll_gap_i = 1; resp_mode = 1;
    run_cmd(2'd0, 16'h0005);
    chk(err_o && !cr_cap_addr_o, "R7 timeout waiting high", {err_o, cr_cap_addr_o}, 2'b10);
    resp_mode = 2;
    repeat (4) @(negedge clk_i);
    run_cmd(2'd2, 16'h0000);
    chk(err_o && !cr_read_o, "R7 timeout waiting low", {err_o, cr_read_o}, 2'b10);
    resp_mode = 0; resp_lag = 1;
    repeat (4) @(negedge clk_i);

    poll_gap_i = 2;
    while (!ready_o) @(negedge clk_i);
    req_i = 1; op_i = 2'd0; wdata_i = 16'h1111;
    @(negedge clk_i);
    op_i = 2'd1; wdata_i = 16'hFFFF;
    @(negedge clk_i);
    req_i = 0;
    chk(!ready_o && cr_din_o == 16'h1111, "R8 busy request ignored", cr_din_o, 16'h1111);
    while (!done_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    chk(ready_o && !cr_cap_data_o && cr_din_o == 16'h1111, "R8 no second command", cr_din_o, 16'h1111);

    req_i = 1; op_i = 2'd3; wdata_i = 16'hABCD;
    @(negedge clk_i);
    req_i = 0;
    @(negedge clk_i);
    chk(ready_o && !done_o && cr_din_o == 16'h1111 &&
        {cr_read_o, cr_write_o, cr_cap_data_o, cr_cap_addr_o} == 0, "R8 op 3 ignored", cr_din_o, 16'h1111);

    repeat (5) @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule